// File: doc/BRIEF.md
# Integer Multiply/Divide Unit with HI/LO Result Registers

This block is the long-latency integer arithmetic engine that sits beside the main ALU of a 64-bit core. An issuing pipeline hands it an opcode and two 64-bit operands. It then runs a signed or unsigned multiply or divide, at 32 or 64 bits, over a fixed number of cycles for that opcode. When the count expires it writes the two result halves into a dedicated pair of result registers, HI and LO.

While the unit is working, unrelated integer instructions keep flowing. The pipeline only has to wait when it reads HI or LO before the result has landed, or when it offers another multiply/divide too early. In either case the unit raises a stall request. The pipeline can also load HI and LO directly through move-to writes.

Top module: `muldiv_unit`

## Requirements
- R1: After a start is accepted, `busy_o` stays high for exactly the opcode's latency: 8 cycles for a 32-bit multiply, 12 for a 64-bit multiply, 36 for a 32-bit divide and 68 for a 64-bit divide. The results are visible on `hi_o`/`lo_o` in the first cycle that `busy_o` is low.
- R2: The repeat interval equals the latency. A start offered in the last busy cycle is accepted at the next edge, with no idle gap. A start offered earlier raises `stall_o` and is not accepted.
- R3: A HI/LO read request (`rd_req_i`) while `busy_o` is high raises `stall_o`. With the unit idle, a read produces no stall.
- R4: A multiply places the low half of the product in LO and the high half in HI. For 64-bit operands the full 128-bit product is kept.
- R5: 32-bit operations use only bits 31:0 of each operand. Those bits are sign-extended for signed ops and zero-extended for unsigned ops. Each 32-bit result half is sign-extended from bit 31 to 64 bits.
- R6: A divide places the quotient, truncated toward zero, in LO. It places the remainder, which carries the sign of the dividend, in HI.
- R7: A divide by zero does not trap. LO becomes all ones and HI becomes the (extended) dividend.
- R8: `mthi_i`/`mtlo_i` load `mt_data_i` into HI/LO at the next edge, including while the unit is busy. When a result is written at the same edge, the result takes priority.
- R9: Opcode encoding on `op_i`: 0 signed 32-bit multiply, 1 unsigned 32-bit multiply, 2 signed 64-bit multiply, 3 unsigned 64-bit multiply, 4 signed 32-bit divide, 5 unsigned 32-bit divide, 6 signed 64-bit divide, 7 unsigned 64-bit divide. Bit 2 selects divide, bit 1 selects 64-bit width, and bit 0 selects unsigned.
- R10: During and after reset, HI and LO read zero and both `busy_o` and `stall_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Issue request for a multiply/divide |
| op_i | input | 3 | Opcode (see R9) |
| opa_i | input | 64 | Multiplicand or dividend |
| opb_i | input | 64 | Multiplier or divisor |
| busy_o | output | 1 | An operation is in flight |
| rd_req_i | input | 1 | Pipeline wants to read HI or LO this cycle |
| stall_o | output | 1 | Pipeline must hold its current request |
| hi_o | output | 64 | HI register |
| lo_o | output | 64 | LO register |
| mthi_i | input | 1 | Move-to-HI write enable |
| mtlo_i | input | 1 | Move-to-LO write enable |
| mt_data_i | input | 64 | Move-to data |

## Verification
On every cycle, the assertions check three things. A stall only occurs while busy, and an early read always stalls. At the cycle the latency counter expires, the multiply or divide engine has finished its iterations. HI and LO change only on a result write or a move. The exact cycle counts per opcode, the arithmetic values across sign combinations, divide-by-zero, the back-to-back hand-off and the priority of a result over a coincident move can only be shown by the bench's scenarios. The bench compares each of these against a reference computed from the requirements.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  localparam int XLEN = 64;
  localparam int HLEN = XLEN / 2;

  typedef enum logic [2:0] {
    OP_MUL_S32 = 3'd0,
    OP_MUL_U32 = 3'd1,
    OP_MUL_S64 = 3'd2,
    OP_MUL_U64 = 3'd3,
    OP_DIV_S32 = 3'd4,
    OP_DIV_U32 = 3'd5,
    OP_DIV_S64 = 3'd6,
    OP_DIV_U64 = 3'd7
  } md_op_e;

  function automatic logic op_is_div(input logic [2:0] op);
    return op[2];
  endfunction

  function automatic logic op_is_wide(input logic [2:0] op);
    return op[1];
  endfunction

  function automatic logic op_is_signed(input logic [2:0] op);
    return ~op[0];
  endfunction
endpackage

// File: rtl/muldiv_seq.sv
module muldiv_seq #(
  parameter int LAT_M32 = 8,
  parameter int LAT_M64 = 12,
  parameter int LAT_D32 = 36,
  parameter int LAT_D64 = 68
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [2:0] op_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       accept_o
);
  localparam int LAT_A   = (LAT_M32 > LAT_M64) ? LAT_M32 : LAT_M64;
  localparam int LAT_B   = (LAT_D32 > LAT_D64) ? LAT_D32 : LAT_D64;
  localparam int LAT_MAX = (LAT_A > LAT_B) ? LAT_A : LAT_B;
  localparam int CW      = $clog2(LAT_MAX + 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] lat_m1;

  always_comb begin
    unique case ({op_i[2], op_i[1]})
      2'b00:   lat_m1 = CW'(LAT_M32 - 1);
      2'b01:   lat_m1 = CW'(LAT_M64 - 1);
      2'b10:   lat_m1 = CW'(LAT_D32 - 1);
      default: lat_m1 = CW'(LAT_D64 - 1);
    endcase
  end

  assign done_o   = busy_q && (cnt_q == '0);
  assign accept_o = start_i && (!busy_q || done_o);
  assign busy_o   = busy_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (accept_o) begin
      busy_d = 1'b1;
      cnt_d  = lat_m1;
    end else if (done_o) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> busy_o); // R1
  AST_FINISH_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> !busy_o); // R1
endmodule

// File: rtl/muldiv_mul.sv
module muldiv_mul #(
  parameter int XLEN      = 64,
  parameter int STEP_BITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [XLEN-1:0]   mcand_i,
  input  logic [XLEN-1:0]   mplier_i,
  output logic [2*XLEN-1:0] prod_o,
  output logic              idle_o
);
  localparam int PW = 2 * XLEN;

  logic [PW-1:0]   acc_q, acc_d;
  logic [PW-1:0]   mc_q, mc_d;
  logic [XLEN-1:0] mp_q, mp_d;
  logic [PW-1:0]   partial;
  logic            en;

  assign idle_o  = (mp_q == '0);
  assign en      = load_i || !idle_o;
  assign partial = mc_q * {{(PW-STEP_BITS){1'b0}}, mp_q[STEP_BITS-1:0]};

  always_comb begin
    if (load_i) begin
      acc_d = '0;
      mc_d  = {{XLEN{1'b0}}, mcand_i};
      mp_d  = mplier_i;
    end else begin
      acc_d = acc_q + partial;
      mc_d  = mc_q << STEP_BITS;
      mp_d  = mp_q >> STEP_BITS;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      mc_q  <= '0;
      mp_q  <= '0;
    end else if (en) begin
      acc_q <= acc_d;
      mc_q  <= mc_d;
      mp_q  <= mp_d;
    end
  end

  assign prod_o = acc_q;
endmodule

// File: rtl/muldiv_div.sv
module muldiv_div #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic            wide_i,
  input  logic [XLEN-1:0] dvd_i,
  input  logic [XLEN-1:0] dvs_i,
  output logic [XLEN-1:0] quo_o,
  output logic [XLEN-1:0] rem_o,
  output logic            idle_o
);
  localparam int HLEN = XLEN / 2;
  localparam int SW   = $clog2(XLEN + 1);

  logic [XLEN-1:0] rem_q, rem_d;
  logic [XLEN-1:0] quo_q, quo_d;
  logic [XLEN-1:0] dvs_q, dvs_d;
  logic [SW-1:0]   steps_q, steps_d;
  logic [XLEN:0]   shifted, trial;
  logic            en;

  assign idle_o  = (steps_q == '0);
  assign en      = load_i || !idle_o;
  assign shifted = {rem_q, quo_q[XLEN-1]};
  assign trial   = shifted - {1'b0, dvs_q};

  always_comb begin
    if (load_i) begin
      rem_d   = '0;
      quo_d   = wide_i ? dvd_i : {dvd_i[HLEN-1:0], {HLEN{1'b0}}};
      dvs_d   = dvs_i;
      steps_d = wide_i ? SW'(XLEN) : SW'(HLEN);
    end else begin
      dvs_d   = dvs_q;
      steps_d = steps_q - 1'b1;
      if (!trial[XLEN]) begin
        rem_d = trial[XLEN-1:0];
        quo_d = {quo_q[XLEN-2:0], 1'b1};
      end else begin
        rem_d = shifted[XLEN-1:0];
        quo_d = {quo_q[XLEN-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q   <= '0;
      quo_q   <= '0;
      dvs_q   <= '0;
      steps_q <= '0;
    end else if (en) begin
      rem_q   <= rem_d;
      quo_q   <= quo_d;
      dvs_q   <= dvs_d;
      steps_q <= steps_d;
    end
  end

  assign quo_o = quo_q;
  assign rem_o = rem_q;
endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            res_we_i,
  input  logic [XLEN-1:0] res_hi_i,
  input  logic [XLEN-1:0] res_lo_i,
  input  logic            mv_hi_we_i,
  input  logic            mv_lo_we_i,
  input  logic [XLEN-1:0] mv_data_i,
  output logic [XLEN-1:0] hi_o,
  output logic [XLEN-1:0] lo_o
);
  logic [XLEN-1:0] hi_q, hi_d, lo_q, lo_d;

  always_comb begin
    hi_d = hi_q;
    lo_d = lo_q;
    if (res_we_i) begin
      hi_d = res_hi_i;
      lo_d = res_lo_i;
    end else begin
      if (mv_hi_we_i) hi_d = mv_data_i;
      if (mv_lo_we_i) lo_d = mv_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;

  AST_HI_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_we_i && !mv_hi_we_i) |=> $stable(hi_o)); // R8
  AST_RESULT_BEATS_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_we_i && mv_lo_we_i) |=> (lo_o == $past(res_lo_i))); // R8
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
  parameter int XLEN      = 64,
  parameter int MUL_STEP  = 8,
  parameter int LAT_M32   = 8,
  parameter int LAT_M64   = 12,
  parameter int LAT_D32   = 36,
  parameter int LAT_D64   = 68
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [2:0]      op_i,
  input  logic [XLEN-1:0] opa_i,
  input  logic [XLEN-1:0] opb_i,
  output logic            busy_o,
  input  logic            rd_req_i,
  output logic            stall_o,
  output logic [XLEN-1:0] hi_o,
  output logic [XLEN-1:0] lo_o,
  input  logic            mthi_i,
  input  logic            mtlo_i,
  input  logic [XLEN-1:0] mt_data_i
);
  import muldiv_pkg::*;

  localparam int HW = XLEN / 2;

  logic            accept, done;
  logic            sgn, wide;
  logic [XLEN-1:0] a_ext, b_ext, a_mag, b_mag;
  logic            a_neg, b_neg;

  // captured context of the running operation
  logic            is_div_q, wide_q, a_neg_q, b_neg_q, b_zero_q;
  logic [XLEN-1:0] a_ext_q;

  logic [2*XLEN-1:0] prod, sprod;
  logic              mul_idle, div_idle;
  logic [XLEN-1:0]   quo, rem, sq, sr;
  logic [XLEN-1:0]   res_hi, res_lo;

  assign sgn  = op_is_signed(op_i);
  assign wide = op_is_wide(op_i);

  always_comb begin
    if (wide) begin
      a_ext = opa_i;
      b_ext = opb_i;
    end else begin
      a_ext = {{(XLEN-HW){sgn & opa_i[HW-1]}}, opa_i[HW-1:0]};
      b_ext = {{(XLEN-HW){sgn & opb_i[HW-1]}}, opb_i[HW-1:0]};
    end
    a_neg = sgn & a_ext[XLEN-1];
    b_neg = sgn & b_ext[XLEN-1];
    a_mag = a_neg ? (~a_ext + 1'b1) : a_ext;
    b_mag = b_neg ? (~b_ext + 1'b1) : b_ext;
  end

  muldiv_seq #(
    .LAT_M32(LAT_M32), .LAT_M64(LAT_M64), .LAT_D32(LAT_D32), .LAT_D64(LAT_D64)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .busy_o(busy_o), .done_o(done), .accept_o(accept)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_div_q <= 1'b0;
      wide_q   <= 1'b0;
      a_neg_q  <= 1'b0;
      b_neg_q  <= 1'b0;
      b_zero_q <= 1'b0;
      a_ext_q  <= '0;
    end else if (accept) begin
      is_div_q <= op_is_div(op_i);
      wide_q   <= wide;
      a_neg_q  <= a_neg;
      b_neg_q  <= b_neg;
      b_zero_q <= (b_ext == '0);
      a_ext_q  <= a_ext;
    end
  end

  muldiv_mul #(.XLEN(XLEN), .STEP_BITS(MUL_STEP)) u_mul (
    .clk(clk), .rst_n(rst_n), .load_i(accept),
    .mcand_i(a_mag), .mplier_i(b_mag), .prod_o(prod), .idle_o(mul_idle)
  );

  muldiv_div #(.XLEN(XLEN)) u_div (
    .clk(clk), .rst_n(rst_n), .load_i(accept), .wide_i(wide),
    .dvd_i(a_mag), .dvs_i(b_mag), .quo_o(quo), .rem_o(rem), .idle_o(div_idle)
  );

  // sign restoration and result formatting
  always_comb begin
    sprod = (a_neg_q ^ b_neg_q) ? (~prod + 1'b1) : prod;
    sq    = (a_neg_q ^ b_neg_q) ? (~quo + 1'b1) : quo;
    sr    = a_neg_q ? (~rem + 1'b1) : rem;
    if (b_zero_q) begin
      sq = '1;
      sr = a_ext_q;
    end
    if (!is_div_q) begin
      if (wide_q) begin
        res_hi = sprod[2*XLEN-1:XLEN];
        res_lo = sprod[XLEN-1:0];
      end else begin
        res_hi = {{(XLEN-HW){sprod[2*HW-1]}}, sprod[2*HW-1:HW]};
        res_lo = {{(XLEN-HW){sprod[HW-1]}}, sprod[HW-1:0]};
      end
    end else begin
      if (wide_q) begin
        res_hi = sr;
        res_lo = sq;
      end else begin
        res_hi = {{(XLEN-HW){sr[HW-1]}}, sr[HW-1:0]};
        res_lo = {{(XLEN-HW){sq[HW-1]}}, sq[HW-1:0]};
      end
    end
  end

  muldiv_hilo #(.XLEN(XLEN)) u_hilo (
    .clk(clk), .rst_n(rst_n), .res_we_i(done),
    .res_hi_i(res_hi), .res_lo_i(res_lo),
    .mv_hi_we_i(mthi_i), .mv_lo_we_i(mtlo_i), .mv_data_i(mt_data_i),
    .hi_o(hi_o), .lo_o(lo_o)
  );

  assign stall_o = busy_o && (rd_req_i || (start_i && !done));

  AST_STALL_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> busy_o); // R3
  AST_EARLY_READ_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_i && busy_o) |-> stall_o); // R3
  AST_DIV_STEPS_FIT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && is_div_q) |-> div_idle); // R1
  AST_MUL_STEPS_FIT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !is_div_q) |-> mul_idle); // R4
endmodule

// File: tb/sim_muldiv_unit.sv
module sim_muldiv_unit;
  logic        clk, rst_n, start_i, rd_req_i, mthi_i, mtlo_i;
  logic [2:0]  op_i;
  logic [63:0] opa_i, opb_i, mt_data_i, hi_o, lo_o;
  logic        busy_o, stall_o;
  int          total, fails;

  muldiv_unit u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .opa_i(opa_i), .opb_i(opb_i), .busy_o(busy_o), .rd_req_i(rd_req_i),
    .stall_o(stall_o), .hi_o(hi_o), .lo_o(lo_o), .mthi_i(mthi_i),
    .mtlo_i(mtlo_i), .mt_data_i(mt_data_i)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int lat_of(input logic [2:0] op);
    case ({op[2], op[1]})
      2'b00:   return 8;
      2'b01:   return 12;
      2'b10:   return 36;
      default: return 68;
    endcase
  endfunction

  function automatic logic [63:0] sx32(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  // reference built from R4..R7 and R9
  task automatic ref_calc(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b,
                          output logic [63:0] hi, output logic [63:0] lo);
    logic         sgn;
    logic [63:0]  ae, be, q, r;
    logic [127:0] up;
    logic signed [127:0] sp;
    sgn = !op[0];
    if (op[1]) begin ae = a; be = b; end
    else begin
      ae = sgn ? sx32(a[31:0]) : {32'b0, a[31:0]};
      be = sgn ? sx32(b[31:0]) : {32'b0, b[31:0]};
    end
    if (!op[2]) begin
      if (sgn) begin
        sp = $signed({{64{ae[63]}}, ae}) * $signed({{64{be[63]}}, be});
        up = sp;
      end else up = {64'b0, ae} * {64'b0, be};
      if (op[1]) begin hi = up[127:64]; lo = up[63:0]; end
      else begin hi = sx32(up[63:32]); lo = sx32(up[31:0]); end
    end else begin
      if (be == 64'd0) begin q = '1; r = ae; end
      else if (sgn) begin q = $signed(ae) / $signed(be); r = $signed(ae) % $signed(be); end
      else begin q = ae / be; r = ae % be; end
      if (op[1]) begin hi = r; lo = q; end
      else begin hi = sx32(r[31:0]); lo = sx32(q[31:0]); end
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start_i = 0; rd_req_i = 0; mthi_i = 0; mtlo_i = 0;
    op_i = 0; opa_i = 0; opb_i = 0; mt_data_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "hi after reset", hi_o, 64'd0);
    chk("R10", "lo after reset", lo_o, 64'd0);
    chk("R10", "busy after reset", {63'd0, busy_o}, 64'd0);
    rd_req_i = 1;
    #1;
    chk("R10", "stall after reset", {63'd0, stall_o}, 64'd0);
    rd_req_i = 0;
  endtask

  task automatic t_op(input string req, input logic [2:0] op,
                      input logic [63:0] a, input logic [63:0] b);
    int n;
    logic [63:0] eh, el;
    ref_calc(op, a, b, eh, el);
    @(negedge clk);
    op_i = op; opa_i = a; opb_i = b; start_i = 1;
    @(negedge clk);
    start_i = 0;
    n = 0;
    while (busy_o) begin n++; @(negedge clk); end
    chk("R1", $sformatf("latency op %0d", op), 64'(n), 64'(lat_of(op)));
    chk(req, $sformatf("hi op %0d", op), hi_o, eh);
    chk(req, $sformatf("lo op %0d", op), lo_o, el);
  endtask

  task automatic t_back_to_back(input logic [2:0] op1, input logic [63:0] a1, input logic [63:0] b1,
                                input logic [2:0] op2, input logic [63:0] a2, input logic [63:0] b2);
    int t, n;
    logic [63:0] h1, l1, h2, l2;
    ref_calc(op1, a1, b1, h1, l1);
    ref_calc(op2, a2, b2, h2, l2);
    @(negedge clk);
    op_i = op1; opa_i = a1; opb_i = b1; start_i = 1;
    @(negedge clk);
    op_i = op2; opa_i = a2; opb_i = b2;
    t = 0;
    while (stall_o) begin t++; @(negedge clk); end
    chk("R2", "stalled cycles of early start", 64'(t), 64'(lat_of(op1) - 1));
    chk("R2", "busy at hand-off", {63'd0, busy_o}, 64'd1);
    @(negedge clk);
    start_i = 0;
    chk("R2", "first result hi at hand-off", hi_o, h1);
    chk("R2", "first result lo at hand-off", lo_o, l1);
    n = 0;
    while (busy_o) begin n++; @(negedge clk); end
    chk("R2", "second op latency", 64'(n), 64'(lat_of(op2)));
    chk("R2", "second result lo", lo_o, l2);
    chk("R2", "second result hi", hi_o, h2);
  endtask

  task automatic t_read_stall();
    int n;
    logic [63:0] eh, el;
    ref_calc(3'd6, 64'd1000001, 64'd999, eh, el);
    @(negedge clk);
    op_i = 3'd6; opa_i = 64'd1000001; opb_i = 64'd999; start_i = 1;
    @(negedge clk);
    start_i = 0; rd_req_i = 1;
    #1;
    chk("R3", "stall on early read", {63'd0, stall_o}, 64'd1);
    n = 0;
    while (busy_o) begin n++; @(negedge clk); end
    #1;
    chk("R3", "no stall on idle read", {63'd0, stall_o}, 64'd0);
    chk("R6", "quotient after stalled read", lo_o, el);
    rd_req_i = 0;
  endtask

  task automatic t_moves();
    logic [63:0] keep_lo, eh, el;
    keep_lo = lo_o;
    @(negedge clk);
    mthi_i = 1; mt_data_i = 64'h0123_4567_89AB_CDEF;
    @(negedge clk);
    mthi_i = 0;
    chk("R8", "move to hi", hi_o, 64'h0123_4567_89AB_CDEF);
    chk("R8", "lo untouched by move to hi", lo_o, keep_lo);
    mtlo_i = 1; mt_data_i = 64'hFEDC_BA98_7654_3210;
    @(negedge clk);
    mtlo_i = 0;
    chk("R8", "move to lo", lo_o, 64'hFEDC_BA98_7654_3210);
    // move while busy, then a move coinciding with the result write
    ref_calc(3'd1, 64'd77, 64'd91, eh, el);
    op_i = 3'd1; opa_i = 64'd77; opb_i = 64'd91; start_i = 1;
    @(negedge clk);
    start_i = 0; mtlo_i = 1; mt_data_i = 64'h5555_AAAA_5555_AAAA;
    @(negedge clk);
    chk("R8", "move to lo while busy", lo_o, 64'h5555_AAAA_5555_AAAA);
    while (busy_o) @(negedge clk);
    mtlo_i = 0;
    chk("R8", "result wins over coincident move", lo_o, el);
  endtask

  initial begin
    total = 0; fails = 0;
    t_reset();
    t_op("R4", 3'd0, 64'hDEAD_BEEF_FFFF_FFF9, 64'h1234_5678_0001_E240);
    t_op("R5", 3'd0, 64'h0000_0000_7FFF_FFFF, 64'h0000_0000_7FFF_FFFF);
    t_op("R5", 3'd1, 64'hAAAA_AAAA_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF);
    t_op("R4", 3'd2, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFD);
    t_op("R4", 3'd2, 64'h0000_1234_5678_9ABC, 64'hFFFF_FFFF_0000_0001);
    t_op("R4", 3'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    t_op("R6", 3'd4, 64'hFFFF_FFFF_FFFF_FF8D, 64'd10);
    t_op("R6", 3'd4, 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_FFFF_FFFF);
    t_op("R5", 3'd5, 64'h1111_1111_FFFF_FFF0, 64'h2222_2222_0000_0007);
    t_op("R6", 3'd6, 64'd1000, 64'hFFFF_FFFF_FFFF_FFF9);
    t_op("R6", 3'd6, 64'hFFFF_FFFF_FFFF_F000, 64'hFFFF_FFFF_FFFF_FFF3);
    t_op("R6", 3'd7, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3);
    t_op("R7", 3'd6, 64'hFFFF_FFFF_FFFF_FF00, 64'd0);
    t_op("R7", 3'd4, 64'h0000_0001_8000_0001, 64'h0000_0005_0000_0000);
    t_op("R7", 3'd7, 64'd42, 64'd0);
    t_back_to_back(3'd0, 64'd6, 64'd7, 3'd7, 64'd100, 64'd9);
    t_back_to_back(3'd2, 64'hFFFF_FFFF_FFFF_FFFE, 64'd3, 3'd1, 64'd5, 64'd5);
    t_read_stall();
    t_moves();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule